// File: doc/BRIEF.md
# Cam-Style Preset Output Sequencer

This block turns a running count into a sequence of output patterns. It keeps a small table in which every entry pairs a compare value with an output bit pattern. A pointer selects the active entry. While the live count is below that entry's compare value, the entry's pattern drives the outputs. Above or at the compare value, the outputs read zero.

Each count-equals event from the external counter moves the pointer one entry forward. An index event, such as an encoder's once-per-turn pulse, sends the pointer back to the first entry so the cycle repeats. One comparator serves the whole table because the pointer moves far less often than the count does.

The table is loaded through a single write port while the sequencer is disabled. Enabling the sequencer starts it at the first entry. A parameter chooses what happens at the end of the table: by default the pointer stays on the last entry until an index event arrives, and the alternative returns it to the first entry.

Top module: `cam_sequencer`

## Requirements
- R1: After reset, step_idx is 0, out_pat is all zero, and every table entry holds compare value 0 and pattern 0.
- R2: While enable is low, step_idx is held at 0 and out_pat is zero from the next clock. When enable rises, the sequence starts at entry 0.
- R3: While enable is high, out_pat at each clock becomes the pattern of the entry selected for that clock when cnt_val is unsigned-less-than that entry's compare value, and all zero otherwise. The output is registered, so an event is seen on out_pat exactly one clock later.
- R4: With enable high, idx_evt sets step_idx to 0 on the next clock, and it takes priority over eq_evt in the same cycle.
- R5: With enable high, idx_evt low and step_idx below DEPTH-1, eq_evt raises step_idx by one on the next clock.
- R6: With enable high and neither event present, step_idx does not change.
- R7: With enable high, an eq_evt on entry DEPTH-1 leaves step_idx at DEPTH-1 (default, WRAP_AT_END=0). With WRAP_AT_END=1 it returns step_idx to 0.
- R8: A write (wr_en high) stores wr_preset and wr_pattern into entry wr_addr only while enable is low. While enable is high, writes are ignored and the table keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the sequencer; while it is low, table writes are allowed |
| cnt_val | input | CNT_W | Live count from the external counter (unsigned) |
| eq_evt | input | 1 | Count-equals-compare event; advances the pointer |
| idx_evt | input | 1 | Index event; returns the pointer to entry 0 |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | IDX_W | Table entry to write |
| wr_preset | input | CNT_W | Compare value to write |
| wr_pattern | input | OUT_W | Output pattern to write |
| out_pat | output | OUT_W | Registered output pattern |
| step_idx | output | IDX_W | Index of the active entry |

## Verification
A wrong pointer shows on step_idx one clock after the event that caused it. It also shows on out_pat in that same clock as the pattern of the wrong entry. A corrupt or torn table entry cannot be read directly. It appears as a wrong pattern on out_pat, or as a wrong switch-off count, on the first clock after the pointer reaches that entry. The bench therefore checks the pattern, and sweeps the count across the compare value, right after each step. This covers entries that were written both while disabled and while enabled.

// File: rtl/cam_seq_pkg.sv
package cam_seq_pkg;

   // Pointer action chosen each clock
   typedef enum logic [1:0] {
      ACT_KEEP = 2'd0,
      ACT_NEXT = 2'd1,
      ACT_HOME = 2'd2,
      ACT_LAST = 2'd3
   } step_act_e;

endpackage

// File: rtl/cam_table.sv
module cam_table #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 32,
   parameter int OUT_W = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [CNT_W-1:0] wr_preset,
   input  logic [OUT_W-1:0] wr_pattern,
   input  logic [IDX_W-1:0] rd_addr,
   output logic [CNT_W-1:0] rd_preset,
   output logic [OUT_W-1:0] rd_pattern
);

   logic [CNT_W-1:0] preset_mem [DEPTH];
   logic [OUT_W-1:0] pat_mem    [DEPTH];
   logic             addr_ok;

   generate
      if (DEPTH == (1 << IDX_W)) begin : g_full_range
         assign addr_ok = 1'b1;
      end else begin : g_part_range
         assign addr_ok = (32'(wr_addr) < 32'(DEPTH));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            preset_mem[i] <= '0;
            pat_mem[i]    <= '0;
         end
      end else if (wr_en && !lock && addr_ok) begin
         preset_mem[wr_addr] <= wr_preset;
         pat_mem[wr_addr]    <= wr_pattern;
      end
   end

   assign rd_preset  = preset_mem[rd_addr];
   assign rd_pattern = pat_mem[rd_addr];

endmodule

// File: rtl/cam_step_ctrl.sv
module cam_step_ctrl
   import cam_seq_pkg::*;
#(
   parameter int DEPTH       = 8,
   parameter bit WRAP_AT_END = 1'b0,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             eq_evt,
   input  logic             idx_evt,
   output logic [IDX_W-1:0] step_nxt,
   output logic [IDX_W-1:0] step_q
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   step_act_e act;
   logic [IDX_W-1:0] end_target;

   generate
      if (WRAP_AT_END) begin : g_wrap
         assign end_target = '0;
      end else begin : g_hold
         assign end_target = LAST_IDX;
      end
   endgenerate

   always_comb begin
      if (!enable || idx_evt)       act = ACT_HOME;
      else if (!eq_evt)             act = ACT_KEEP;
      else if (step_q == LAST_IDX)  act = ACT_LAST;
      else                          act = ACT_NEXT;
   end

   always_comb begin
      unique case (act)
         ACT_HOME: step_nxt = '0;
         ACT_NEXT: step_nxt = step_q + 1'b1;
         ACT_LAST: step_nxt = end_target;
         default:  step_nxt = step_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= '0;
      else        step_q <= step_nxt;
   end

endmodule

// File: rtl/cam_out_stage.sv
module cam_out_stage #(
   parameter int CNT_W = 32,
   parameter int OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [OUT_W-1:0] pattern,
   output logic [OUT_W-1:0] out_q
);

   logic below;
   assign below = (cnt_val < cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 out_q <= '0;
      else if (enable && below)   out_q <= pattern;
      else                        out_q <= '0;
   end

endmodule

// File: rtl/cam_sequencer.sv
module cam_sequencer #(
   parameter int DEPTH       = 8,
   parameter int CNT_W       = 32,
   parameter int OUT_W       = 8,
   parameter bit WRAP_AT_END = 1'b0,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             eq_evt,
   input  logic             idx_evt,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [CNT_W-1:0] wr_preset,
   input  logic [OUT_W-1:0] wr_pattern,
   output logic [OUT_W-1:0] out_pat,
   output logic [IDX_W-1:0] step_idx
);

   generate
      if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
         $error("cam_sequencer: DEPTH must lie in 2..256");
      end
      if (CNT_W < 1 || CNT_W > 64) begin : g_bad_cnt
         $error("cam_sequencer: CNT_W must lie in 1..64");
      end
      if (OUT_W < 1) begin : g_bad_out
         $error("cam_sequencer: OUT_W must be at least 1");
      end
   endgenerate

   logic [IDX_W-1:0] step_nxt;
   logic [CNT_W-1:0] sel_preset;
   logic [OUT_W-1:0] sel_pattern;

   cam_step_ctrl #(
      .DEPTH       (DEPTH),
      .WRAP_AT_END (WRAP_AT_END)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .eq_evt   (eq_evt),
      .idx_evt  (idx_evt),
      .step_nxt (step_nxt),
      .step_q   (step_idx)
   );

   cam_table #(
      .DEPTH (DEPTH),
      .CNT_W (CNT_W),
      .OUT_W (OUT_W)
   ) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock       (enable),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_preset  (wr_preset),
      .wr_pattern (wr_pattern),
      .rd_addr    (step_nxt),
      .rd_preset  (sel_preset),
      .rd_pattern (sel_pattern)
   );

   cam_out_stage #(
      .CNT_W (CNT_W),
      .OUT_W (OUT_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .cnt_val (cnt_val),
      .cmp_val (sel_preset),
      .pattern (sel_pattern),
      .out_q   (out_pat)
   );

endmodule

// File: rtl/cam_sequencer_chk.sv
module cam_sequencer_chk #(
   parameter int DEPTH       = 8,
   parameter int OUT_W       = 8,
   parameter bit WRAP_AT_END = 1'b0,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             eq_evt,
   input logic             idx_evt,
   input logic [IDX_W-1:0] step_idx,
   input logic [OUT_W-1:0] out_pat
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   a_r2_idle_home: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (step_idx == '0));

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (out_pat == '0));

   a_r4_index_home: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && idx_evt) |=> (step_idx == '0));

   a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !idx_evt && eq_evt && step_idx != LAST_IDX)
         |=> (step_idx == $past(step_idx) + 1'b1));

   a_r6_no_event_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !idx_evt && !eq_evt) |=> $stable(step_idx));

   a_r7_end_of_table: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !idx_evt && eq_evt && step_idx == LAST_IDX)
         |=> (step_idx == (WRAP_AT_END ? '0 : LAST_IDX)));

   a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      32'(step_idx) < 32'(DEPTH));

endmodule

bind cam_sequencer cam_sequencer_chk #(
   .DEPTH       (DEPTH),
   .OUT_W       (OUT_W),
   .WRAP_AT_END (WRAP_AT_END)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .eq_evt   (eq_evt),
   .idx_evt  (idx_evt),
   .step_idx (step_idx),
   .out_pat  (out_pat)
);

// File: tb/tb_cam_sequencer.sv
module tb_cam_sequencer;

   localparam int DEPTH = 8;
   localparam int CNT_W = 32;
   localparam int OUT_W = 8;
   localparam int IDX_W = $clog2(DEPTH);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic [CNT_W-1:0] cnt_val = '0;
   logic             eq_evt = 1'b0;
   logic             idx_evt = 1'b0;
   logic             wr_en = 1'b0;
   logic [IDX_W-1:0] wr_addr = '0;
   logic [CNT_W-1:0] wr_preset = '0;
   logic [OUT_W-1:0] wr_pattern = '0;
   logic [OUT_W-1:0] out_pat;
   logic [IDX_W-1:0] step_idx;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   cam_sequencer #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OUT_W(OUT_W)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cnt_val(cnt_val),
      .eq_evt(eq_evt), .idx_evt(idx_evt), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_preset(wr_preset), .wr_pattern(wr_pattern),
      .out_pat(out_pat), .step_idx(step_idx)
   );

   function automatic logic [CNT_W-1:0] ref_pre(int i);
      return CNT_W'(100 * (i + 1));
   endfunction

   function automatic logic [OUT_W-1:0] ref_pat(int i);
      return OUT_W'((i * 37 + 5) & 255);
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [CNT_W-1:0] p, logic [OUT_W-1:0] q);
      wr_en = 1'b1; wr_addr = IDX_W'(a); wr_preset = p; wr_pattern = q;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 step", 32'(step_idx), 0);
      chk("R1 out", 32'(out_pat), 0);
      enable = 1'b1; cnt_val = '0;
      tick();
      chk("R1 empty table pattern", 32'(out_pat), 0);
      enable = 1'b0;
      tick();
   endtask

   task automatic t_load();
      for (int i = 0; i < DEPTH; i++) wr(i, ref_pre(i), ref_pat(i));
   endtask

   task automatic t_below();
      enable = 1'b1; cnt_val = 50;
      tick();
      chk("R2 start entry", 32'(step_idx), 0);
      chk("R3 below compare", 32'(out_pat), 32'(ref_pat(0)));
      cnt_val = 100;
      tick();
      chk("R3 at compare", 32'(out_pat), 0);
      chk("R6 no event", 32'(step_idx), 0);
   endtask

   task automatic t_walk();
      for (int i = 0; i < DEPTH - 1; i++) begin
         cnt_val = ref_pre(i); eq_evt = 1'b1;
         tick();
         chk("R5 advance", 32'(step_idx), i + 1);
         chk("R3 next pattern", 32'(out_pat), 32'(ref_pat(i + 1)));
      end
      eq_evt = 1'b0;
      tick();
      chk("R6 held", 32'(step_idx), DEPTH - 1);
      cnt_val = ref_pre(DEPTH - 1); eq_evt = 1'b1;
      tick();
      eq_evt = 1'b0;
      chk("R7 stay on last", 32'(step_idx), DEPTH - 1);
      chk("R7 out off", 32'(out_pat), 0);
   endtask

   task automatic t_index();
      cnt_val = 10; idx_evt = 1'b1; eq_evt = 1'b1;
      tick();
      idx_evt = 1'b0; eq_evt = 1'b0;
      chk("R4 index over eq", 32'(step_idx), 0);
      chk("R4 first pattern", 32'(out_pat), 32'(ref_pat(0)));
   endtask

   task automatic t_locked_write();
      wr(1, 5000, 8'hFF);
      cnt_val = 100; eq_evt = 1'b1;
      tick();
      eq_evt = 1'b0;
      chk("R8 locked write step", 32'(step_idx), 1);
      chk("R8 locked pattern kept", 32'(out_pat), 32'(ref_pat(1)));
      cnt_val = 199;
      tick();
      chk("R8 locked preset below", 32'(out_pat), 32'(ref_pat(1)));
      cnt_val = 200;
      tick();
      chk("R8 locked preset kept", 32'(out_pat), 0);
   endtask

   task automatic t_disable_write();
      enable = 1'b0; cnt_val = 0;
      tick();
      chk("R2 disabled step", 32'(step_idx), 0);
      chk("R2 disabled out", 32'(out_pat), 0);
      wr(1, 5000, 8'hFF);
      enable = 1'b1; cnt_val = 100; eq_evt = 1'b1;
      tick();
      eq_evt = 1'b0;
      chk("R8 written pattern", 32'(out_pat), 32'hFF);
      cnt_val = 4999;
      tick();
      chk("R8 written preset below", 32'(out_pat), 32'hFF);
      cnt_val = 5000;
      tick();
      chk("R8 written preset reached", 32'(out_pat), 0);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_load();
      t_below();
      t_walk();
      t_index();
      t_locked_write();
      t_disable_write();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule